// File: doc/BRIEF.md
# Quadrature-Sampled Edge Phase Detector

This block measures how far the rising edge of a locally synthesized clock sits from the rising edge of a slow reference input. Neither signal is used as a clock. Both arrive as groups of four samples on every sample-clock cycle. The four samples of a group are taken at equally spaced sub-phases, as two sampling clocks 90 degrees apart would produce. Edge times are therefore known to a quarter of the sample period. For example, a 400 MHz sample clock gives the resolution of a 1600 MHz sampler.

A free-running sample-cycle counter stamps each edge. The block takes each reference edge and pairs it with the nearest synthesized-clock edge. It then emits a signed, saturated error in quarter-sample units together with a one-cycle valid strobe. A downstream digital loop filter reads the sign of the error to decide which way to correct. If no synthesized edge follows a reference edge within a programmable number of cycles, the block raises a one-cycle missing-edge strobe and gives no error value. It is intended for references of roughly 15 kHz up to a few MHz.

Top module: `quad_phase_meter`

## Requirements
- R1: Within a sample group, bit 0 is the earliest sub-phase. A rising edge at sub-phase k is a 0 in the sample just before bit k followed by a 1 at bit k. For bit 0, the sample just before it is bit 3 of the previous group. An edge's timestamp is the sample-cycle count times 4 plus k.
- R2: The error is the synthesized edge timestamp minus the reference edge timestamp, in quarter-sample units and in two's complement. It is positive when the synthesized edge comes later. An edge at the same sub-phase of the same group gives 0.
- R3: Two candidates compete for each reference edge: the last synthesized edge before it and the first at or after it. The nearer one wins. On equal distance the later edge wins. When no earlier edge has been seen since reset, the later edge is used.
- R4: A synthesized edge in the same group as the reference edge but at a lower sub-phase counts as an earlier edge. One at the same or a higher sub-phase counts as a later edge.
- R5: Let the timeout input be T. A later synthesized edge is accepted only if it falls in the reference's own group or in one of the T groups after it. Otherwise the block gives a missing-edge strobe and no error strobe, one cycle after group T. With T = 0, only the reference's own group counts.
- R6: Each accepted reference edge yields exactly one outcome, either an error or a missing-edge strobe. Reference edges that arrive while a previous one is still waiting for its synthesized edge are ignored.
- R7: The error saturates to the signed 16-bit range, -32768 to 32767.
- R8: Outcomes are registered. The strobe is high for the one cycle after the group that decides it, and the error output holds its value between error strobes.
- R9: During reset and after it, both strobes and the error output are 0. Inputs already high when reset is released do not count as edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| refSamples | input | 4 | Reference sample group, bit 0 earliest |
| synSamples | input | 4 | Synthesized-clock sample group, bit 0 earliest |
| timeoutCycles | input | 16 | Groups allowed after the reference group for the synthesized edge |
| errValid | output | 1 | One-cycle strobe: phaseErr holds a new error |
| missValid | output | 1 | One-cycle strobe: no synthesized edge within the timeout |
| phaseErr | output | 16 | Signed saturated error in quarter-sample units |

## Verification
Synthesized edges are placed a few sub-phases after the reference edge, at the same sub-phase, and right at a group boundary. These cases show whether the sub-phase weighting and the carry of bit 3 into the next group are correct. Other patterns put one synthesized edge shortly before the reference and one after it, with the earlier one nearer, the later one nearer, or both at equal distance. These cases test candidate choice, tie-breaking and the same-group ordering. Synthesized edges placed exactly at the timeout and one group beyond it, and a second reference pulse placed during the wait, test the window and the rule of one outcome per reference edge. Gaps of tens of thousands of sub-samples on both sides of the reference test saturation, and inputs held high across reset test the start-up case.

// File: rtl/qpm_pkg.sv
package qpm_pkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic capRef;   // a reference edge is accepted this cycle
    logic emitErr;  // publish an error this cycle
    logic emitMiss; // publish a missing-edge strobe this cycle
  } qpm_strobe_t;
endpackage

// File: rtl/qpm_edge_find.sv
module qpm_edge_find #(
  parameter int SUBS  = 4,
  parameter int SUB_W = $clog2(SUBS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SUBS-1:0]  grp,
  output logic             found,
  output logic [SUB_W-1:0] sub
);
  logic          lastBit;
  logic [SUBS:0] ext;
  logic [SUBS-1:0] rise;

  // last sample of the previous group; 1 at reset so held-high inputs are no edge
  always_ff @(posedge clk) begin
    if (!rstN) lastBit <= 1'b1;
    else       lastBit <= grp[SUBS-1];
  end

  assign ext = {grp, lastBit};

  for (genvar k = 0; k < SUBS; k++) begin : g_rise
    assign rise[k] = ext[k+1] & ~ext[k];
  end

  always_comb begin
    found = |rise;
    sub   = '0;
    for (int k = SUBS - 1; k >= 0; k--) begin
      if (rise[k]) sub = SUB_W'(k);
    end
  end
endmodule

// File: rtl/qpm_ctrl.sv
module qpm_ctrl
  import qpm_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            refEdge,
  input  logic            synEdge,
  input  logic            synEarly,
  input  logic [TO_W-1:0] timeoutCycles,
  output qpm_strobe_t     strb,
  output logic            busy
);
  typedef enum logic {ST_IDLE, ST_WAIT} ctrl_state_t;

  ctrl_state_t     state, stateNext;
  logic [TO_W-1:0] waitCnt, waitCntNext;

  always_comb begin
    strb        = '0;
    stateNext   = state;
    waitCntNext = waitCnt;
    unique case (state)
      ST_IDLE: begin
        if (refEdge) begin
          strb.capRef = 1'b1;
          if (synEdge && !synEarly) begin
            strb.emitErr = 1'b1;
          end else if (timeoutCycles == '0) begin
            strb.emitMiss = 1'b1;
          end else begin
            stateNext   = ST_WAIT;
            waitCntNext = TO_W'(1);
          end
        end
      end
      ST_WAIT: begin
        if (synEdge) begin
          strb.emitErr = 1'b1;
          stateNext    = ST_IDLE;
        end else if (waitCnt >= timeoutCycles) begin
          strb.emitMiss = 1'b1;
          stateNext     = ST_IDLE;
        end else begin
          waitCntNext = waitCnt + TO_W'(1);
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitCntNext;
    end
  end

  assign busy = (state == ST_WAIT);
endmodule

// File: rtl/qpm_datapath.sv
module qpm_datapath
  import qpm_pkg::*;
#(
  parameter int SUBS  = 4,
  parameter int CNT_W = 24,
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SUBS-1:0]  refGrp,
  input  logic [SUBS-1:0]  synGrp,
  input  qpm_strobe_t      strb,
  output logic             refEdge,
  output logic             synEdge,
  output logic             synEarly,
  output logic             errValid,
  output logic             missValid,
  output logic [ERR_W-1:0] phaseErr
);
  localparam int SUB_W = $clog2(SUBS);
  localparam int TS_W  = CNT_W + SUB_W;
  localparam logic [TS_W-1:0] POS_LIM = TS_W'((64'd1 << (ERR_W - 1)) - 64'd1);
  localparam logic [TS_W-1:0] NEG_LIM = POS_LIM + TS_W'(1);
  localparam logic [ERR_W-1:0] ERR_MAX = {1'b0, {(ERR_W-1){1'b1}}};
  localparam logic [ERR_W-1:0] ERR_MIN = {1'b1, {(ERR_W-1){1'b0}}};

  logic [SUB_W-1:0] refSub, synSub;
  logic [CNT_W-1:0] sampleCnt;
  logic [TS_W-1:0]  refTs, synTs;
  logic [TS_W-1:0]  lastSynTs, refTsQ, prevTsQ;
  logic             lastSynOk, prevOkQ;
  logic [TS_W-1:0]  effRef, effPrev;
  logic             effPrevOk;
  logic [TS_W-1:0]  dNext, dBack;
  logic             choosePrev;
  logic [ERR_W-1:0] satErr;

  qpm_edge_find #(.SUBS(SUBS), .SUB_W(SUB_W)) u_refEdge (
    .clk(clk), .rstN(rstN), .grp(refGrp), .found(refEdge), .sub(refSub)
  );
  qpm_edge_find #(.SUBS(SUBS), .SUB_W(SUB_W)) u_synEdge (
    .clk(clk), .rstN(rstN), .grp(synGrp), .found(synEdge), .sub(synSub)
  );

  assign refTs    = {sampleCnt, refSub};
  assign synTs    = {sampleCnt, synSub};
  assign synEarly = refEdge && synEdge && (synSub < refSub);

  // reference and earlier-edge candidate: live in the capture cycle, stored after
  always_comb begin
    if (strb.capRef) begin
      effRef    = refTs;
      effPrev   = synEarly ? synTs : lastSynTs;
      effPrevOk = synEarly | lastSynOk;
    end else begin
      effRef    = refTsQ;
      effPrev   = prevTsQ;
      effPrevOk = prevOkQ;
    end
  end

  assign dNext      = synTs - effRef;
  assign dBack      = effRef - effPrev;
  assign choosePrev = effPrevOk && (dBack < dNext);

  always_comb begin
    if (choosePrev) begin
      if (dBack > NEG_LIM) satErr = ERR_MIN;
      else                 satErr = -ERR_W'(dBack);
    end else begin
      if (dNext > POS_LIM) satErr = ERR_MAX;
      else                 satErr = ERR_W'(dNext);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleCnt <= '0;
      lastSynTs <= '0;
      lastSynOk <= 1'b0;
      refTsQ    <= '0;
      prevTsQ   <= '0;
      prevOkQ   <= 1'b0;
      errValid  <= 1'b0;
      missValid <= 1'b0;
      phaseErr  <= '0;
    end else begin
      sampleCnt <= sampleCnt + CNT_W'(1);
      if (synEdge) begin
        lastSynTs <= synTs;
        lastSynOk <= 1'b1;
      end
      if (strb.capRef) begin
        refTsQ  <= effRef;
        prevTsQ <= effPrev;
        prevOkQ <= effPrevOk;
      end
      errValid  <= strb.emitErr;
      missValid <= strb.emitMiss;
      if (strb.emitErr) phaseErr <= satErr;
    end
  end
endmodule

// File: rtl/quad_phase_meter.sv
module quad_phase_meter
  import qpm_pkg::*;
#(
  parameter int SUBS  = 4,
  parameter int CNT_W = 24,
  parameter int TO_W  = 16,
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SUBS-1:0]  refSamples,
  input  logic [SUBS-1:0]  synSamples,
  input  logic [TO_W-1:0]  timeoutCycles,
  output logic             errValid,
  output logic             missValid,
  output logic [ERR_W-1:0] phaseErr
);
  qpm_strobe_t strb;
  logic refEdge, synEdge, synEarly, ctrlBusy, refCapture;

  qpm_ctrl #(.TO_W(TO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .refEdge(refEdge), .synEdge(synEdge),
    .synEarly(synEarly), .timeoutCycles(timeoutCycles),
    .strb(strb), .busy(ctrlBusy)
  );

  qpm_datapath #(.SUBS(SUBS), .CNT_W(CNT_W), .ERR_W(ERR_W)) u_dp (
    .clk(clk), .rstN(rstN), .refGrp(refSamples), .synGrp(synSamples),
    .strb(strb), .refEdge(refEdge), .synEdge(synEdge), .synEarly(synEarly),
    .errValid(errValid), .missValid(missValid), .phaseErr(phaseErr)
  );

  assign refCapture = strb.capRef;
endmodule

// File: rtl/qpm_checker.sv
module qpm_checker #(
  parameter int TO_W  = 16,
  parameter int ERR_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             errValid,
  input logic             missValid,
  input logic [ERR_W-1:0] phaseErr,
  input logic             busy,
  input logic             capRef,
  input logic [TO_W-1:0]  timeoutCycles
);
  logic [TO_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + TO_W'(1);
    else           busyRun <= '0;
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    !(errValid && missValid)); // R6

  AST_RESULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (errValid || missValid) |-> $past(busy || capRef)); // R6

  AST_IDLE_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (errValid || missValid) |-> !busy); // R6

  AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < timeoutCycles)); // R5

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !errValid |-> $stable(phaseErr)); // R8
endmodule

bind quad_phase_meter qpm_checker #(.TO_W(TO_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rstN(rstN), .errValid(errValid), .missValid(missValid),
  .phaseErr(phaseErr), .busy(ctrlBusy), .capRef(refCapture),
  .timeoutCycles(timeoutCycles)
);

// File: tb/quad_phase_meter_tb.sv
module quad_phase_meter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  refS = '0, synS = '0;
  logic [15:0] tmo = 16'd10;
  logic        errValid, missValid;
  logic [15:0] phaseErr;
  int nChecks = 0, nFails = 0;
  int nErr, nMiss, lastVal, evCyc;

  always #4 clk = ~clk; // 125 MHz

  quad_phase_meter u_dut (
    .clk(clk), .rstN(rstN), .refSamples(refS), .synSamples(synS),
    .timeoutCycles(tmo), .errValid(errValid), .missValid(missValid),
    .phaseErr(phaseErr)
  );

  // rA, rB, sA, sB (sub-sample positions, -1 none), kind (0 error, 1 miss), value, event cycle, req
  localparam int NV = 11;
  localparam int VEC [NV][8] = '{
    '{40, -1, 43, -1, 0,  3, 11, 2},  // R2 later edge
    '{41, -1, 41, -1, 0,  0, 11, 2},  // R2 same sub-phase
    '{44, -1, 47, -1, 0,  3, 12, 1},  // R1 edge at bit 0 from previous bit 3
    '{42, -1, 39, 60, 0, -3, 16, 3},  // R3 earlier nearer
    '{42, -1, 30, 50, 0,  8, 13, 3},  // R3 later nearer
    '{40, -1, 35, 45, 0,  5, 12, 3},  // R3 tie goes later
    '{43, -1, 41, 70, 0, -2, 18, 4},  // R4 same group, lower sub-phase
    '{40, -1, 83, -1, 0, 43, 21, 5},  // R5 edge in last allowed group
    '{40, -1, 84, -1, 1,  0, 21, 5},  // R5 one group late
    '{42, -1, 40, -1, 1,  0, 21, 5},  // R5 only an earlier edge
    '{40, 60, 70, -1, 0, 30, 18, 6}   // R6 second reference ignored
  };

  function automatic logic lv(int pos, int idx);
    return (pos >= 0) && (idx >= pos) && (idx < pos + 8);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic collect(input int c);
    if (errValid) begin nErr++; lastVal = int'($signed(phaseErr)); evCyc = c; end
    if (missValid) begin nMiss++; evCyc = c; end
  endtask

  task automatic run(input int rA, input int rB, input int sA, input int sB, input int nCyc);
    nErr = 0; nMiss = 0; lastVal = 0; evCyc = -1;
    for (int c = 0; c < nCyc + int'(tmo) + 4; c++) begin
      @(negedge clk);
      collect(c);
      for (int k = 0; k < 4; k++) begin
        refS[k] = lv(rA, c*4+k) | lv(rB, c*4+k);
        synS[k] = lv(sA, c*4+k) | lv(sB, c*4+k);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    // R9: reset state with inputs held high across release
    refS = 4'hF; synS = 4'hF;
    repeat (3) @(negedge clk);
    check(!errValid && !missValid && phaseErr == 0, "R9", "outputs in reset",
          int'(errValid) + int'(missValid) + int'(phaseErr), 0);
    rstN = 1'b1;
    nErr = 0; nMiss = 0;
    for (int c = 0; c < 15; c++) begin @(negedge clk); collect(c); end
    check(nErr == 0 && nMiss == 0, "R9", "events from held-high inputs", nErr + nMiss, 0);
    refS = '0; synS = '0;
    repeat (15) @(negedge clk);

    // main table
    for (int v = 0; v < NV; v++) begin
      run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 30);
      if (VEC[v][4] == 0) begin
        check(nErr == 1 && nMiss == 0, $sformatf("R%0d", VEC[v][7]), $sformatf("vec %0d error count", v), nErr*10 + nMiss, 10);
        check(lastVal == VEC[v][5], $sformatf("R%0d", VEC[v][7]), $sformatf("vec %0d error value", v), lastVal, VEC[v][5]);
      end else begin
        check(nMiss == 1 && nErr == 0, $sformatf("R%0d", VEC[v][7]), $sformatf("vec %0d miss count", v), nErr*10 + nMiss, 1);
      end
      check(evCyc == VEC[v][6], "R8", $sformatf("vec %0d strobe cycle", v), evCyc, VEC[v][6]);
    end

    // R5 with zero timeout: only the reference group counts
    tmo = 16'd0;
    run(40, -1, 41, -1, 30);
    check(nErr == 1 && lastVal == 1, "R5", "zero timeout, same group", lastVal, 1);
    run(40, -1, 44, -1, 30);
    check(nMiss == 1 && nErr == 0, "R5", "zero timeout, next group", nMiss, 1);

    // R7 positive saturation, fresh reset so no earlier edge exists (R3)
    tmo = 16'd9000;
    rstN = 1'b0; repeat (3) @(negedge clk); rstN = 1'b1;
    run(40, -1, 34040, -1, 8530);
    check(nErr == 1 && lastVal == 32767, "R7", "positive saturation", lastVal, 32767);
    // R7 negative saturation: earlier edge 34000 before, later edge 35000 after
    run(34040, -1, 40, 69040, 17280);
    check(nErr == 1 && lastVal == -32768, "R7", "negative saturation", lastVal, -32768);
    // R8: value holds after strobe
    repeat (5) @(negedge clk);
    check(int'($signed(phaseErr)) == -32768 && !errValid, "R8", "error holds", int'($signed(phaseErr)), -32768);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule